// File: doc/BRIEF.md
# Memory and I/O Bus Coprocessor

This block sits between two bus masters, a central processor and a video engine, and one shared external bus. Each master raises a request with a 21-bit address. The block grants one request at a time and classifies the address into a region: dynamic RAM, byte-wide static RAM, a fast or slow peripheral window, or an internal setup register. It then runs the matching pin sequence on the external bus. When the access is over, it returns a one-cycle ready pulse and the read data to the master that owned it.

Dynamic RAM addresses go out in two halves on ten address pins. A row phase comes first and a column phase follows. Data uses twenty lines: the ten upper address/data pins carry data bits 19..10 and the ten data pins carry bits 9..0. Static RAM uses a full 20-bit address, with bits 19..10 on the upper pins and bits 9..0 on the address pins. Its data is one byte on data pins 7..0. Two bits of the setup register take the place of the top two address bits on every static RAM access, so the 256 KB window can page through 1 MB.

The video engine only reads. The processor may read or write.

Top module: `membus_coproc`

## Requirements
- R1: When both masters hold a request while the bus is idle, the video request is granted first. The processor request is served only after the video access completes.
- R2: An address with bit 20 clear is a dynamic RAM access. One row cycle drives address bits 19..10 on `ext_a` with `ext_ras_n` low and `ext_cas_n` high. Then column cycles follow, with bits 9..0 on `ext_a` and both strobes low. The column strobe never falls unless the row strobe was already low.
- R3: Dynamic RAM and peripheral data is 20 bits. Bits 19..10 travel on the upper pins and bits 9..0 on the data pins, in both directions. A read returns the 20-bit word seen on the pins in the last data cycle.
- R4: With bit 20 set, the regions decode as follows. Static RAM fast is 0x180000–0x1BFFFF and static RAM slow is 0x1C0000–0x1FFFFF. The slow peripheral window is 0x120000–0x1203FF and the fast peripheral window is 0x160000–0x1603FF. The setup register is at exactly 0x140000.
- R5: The setup register is 20 bits and resets to zero. A processor write to 0x140000 loads it, and a read of that address returns it. No external pin moves during the access.
- R6: A static RAM access drives the physical address {setup[19:18], addr[17:0]}, with bits 19..10 on the upper pins and bits 9..0 on `ext_a`, and `ext_sram_cs_n` low. A write puts the low byte on data pins 7..0. A read returns that byte zero-extended to 20 bits.
- R7: A peripheral access drives address bits 9..0 on `ext_a` with `ext_io_cs_n` low. Both peripheral windows reach the same 1024 locations.
- R8: Latency is counted in rising edges from a request raised on an idle bus to the edge that raises ready. It is 2+DRAM_CYC for dynamic RAM, 1+FAST_CYC for fast static RAM and fast peripherals, and 1+SLOW_CYC for the slow ones. It is 2 for the setup register and for unmapped addresses. The defaults (2, 2, 4) give 4, 3, 5 and 2.
- R9: Every access produces exactly one ready pulse, one cycle long, and only on the owning master's ready output.
- R10: An address in no region completes with read data zero. No strobe or select is asserted during it.
- R11: At most one of the row strobe, the static RAM select and the peripheral select is active in any cycle. The write strobe is low only while one of those devices is in its data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_req | input | 1 | Video read request, held until ready |
| vid_addr | input | 21 | Video address |
| vid_rdy | output | 1 | One-cycle video completion pulse |
| vid_rdata | output | 20 | Video read data, valid with vid_rdy |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | Processor write when high |
| cpu_addr | input | 21 | Processor address |
| cpu_wdata | input | 20 | Processor write data |
| cpu_rdy | output | 1 | One-cycle processor completion pulse |
| cpu_rdata | output | 20 | Processor read data, valid with cpu_rdy |
| ext_a | output | 10 | Shared address pins |
| ext_hi_o | output | 10 | Upper pins, outgoing value |
| ext_hi_oe | output | 1 | Upper pins drive enable |
| ext_hi_i | input | 10 | Upper pins, incoming value |
| ext_d_o | output | 10 | Data pins, outgoing value |
| ext_d_oe | output | 1 | Data pins drive enable |
| ext_d_i | input | 10 | Data pins, incoming value |
| ext_ras_n | output | 1 | Dynamic RAM row strobe, active low |
| ext_cas_n | output | 1 | Dynamic RAM column strobe, active low |
| ext_sram_cs_n | output | 1 | Static RAM select, active low |
| ext_io_cs_n | output | 1 | Peripheral select, active low |
| ext_we_n | output | 1 | Write strobe, active low |

## Verification
A wrong region decision shows up at the pins within one or two cycles of the grant. Either the wrong select falls, or no select falls and ready comes back early with zero. A bad page value is different: it stays hidden until a static RAM access. It then appears as a wrong upper-pin address and as a byte read from the wrong location. A stuck or miscounted sequencer shifts the ready pulse off its fixed latency, so the edge count taken on every access catches it. A grant to the wrong master shows as ready on the wrong output, or as the processor finishing before the video engine.

// File: rtl/membus_pkg.sv
package membus_pkg;

  localparam int ADDR_W = 21;
  localparam int DATA_W = 20;
  localparam int PIN_W  = 10;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    RG_NONE, RG_DRAM, RG_IO_SLOW, RG_CFG, RG_IO_FAST, RG_SRAM_FAST, RG_SRAM_SLOW
  } region_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ROW, ST_XFER, ST_DONE} seq_st_e;

  typedef struct packed {
    logic               owner_vid;
    logic               we;
    logic [ADDR_W-1:0]  addr;
    logic [DATA_W-1:0]  wdata;
    region_e            rg;
  } xfer_t;

  // Region classification from the 21-bit address.
  function automatic region_e decode_region(input logic [ADDR_W-1:0] a);
    if (!a[20]) return RG_DRAM;
    case (a[19:17])
      3'b001:         return (a[16:10] == '0) ? RG_IO_SLOW : RG_NONE;
      3'b010:         return (a[16:0] == '0)  ? RG_CFG     : RG_NONE;
      3'b011:         return (a[16:10] == '0) ? RG_IO_FAST : RG_NONE;
      3'b100, 3'b101: return RG_SRAM_FAST;
      3'b110, 3'b111: return RG_SRAM_SLOW;
      default:        return RG_NONE;
    endcase
  endfunction

  // Paged static RAM address: setup bits 19..18 replace address bits 19..18.
  function automatic logic [DATA_W-1:0] sram_phys(input logic [ADDR_W-1:0] a,
                                                  input logic [DATA_W-1:0] cfg);
    return {cfg[19:18], a[17:0]};
  endfunction

endpackage

// File: rtl/membus_arb.sv
module membus_arb (
  input  logic en,
  input  logic vid_req,
  input  logic cpu_req,
  output logic gnt_vid,
  output logic gnt_cpu
);
  // Fixed priority: video ahead of processor.
  assign gnt_vid = en & vid_req;
  assign gnt_cpu = en & cpu_req & ~vid_req;
endmodule

// File: rtl/membus_cfg.sv
module membus_cfg #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_data;
  end
endmodule

// File: rtl/membus_seq.sv
module membus_seq
  import membus_pkg::*;
#(
  parameter int DRAM_CYC = 2,
  parameter int FAST_CYC = 2,
  parameter int SLOW_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  xfer_t              start_x,
  input  logic [DATA_W-1:0]  cfg_q,
  output logic               idle,
  output logic               done,
  output logic               done_vid,
  output logic               xfer_last,
  output logic               cfg_we,
  output logic [DATA_W-1:0]  rdata,
  output logic [PIN_W-1:0]   ext_a,
  output logic [PIN_W-1:0]   ext_hi_o,
  output logic               ext_hi_oe,
  input  logic [PIN_W-1:0]   ext_hi_i,
  output logic [PIN_W-1:0]   ext_d_o,
  output logic               ext_d_oe,
  input  logic [PIN_W-1:0]   ext_d_i,
  output logic               ext_ras_n,
  output logic               ext_cas_n,
  output logic               ext_sram_cs_n,
  output logic               ext_io_cs_n,
  output logic               ext_we_n
);
  localparam int MAXC = (DRAM_CYC > FAST_CYC) ?
                        ((DRAM_CYC > SLOW_CYC) ? DRAM_CYC : SLOW_CYC) :
                        ((FAST_CYC > SLOW_CYC) ? FAST_CYC : SLOW_CYC);
  localparam int CW = $clog2(MAXC + 1);

  seq_st_e           st;
  xfer_t             cur;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] cap_data;
  logic [DATA_W-1:0] phys;

  // Data-phase length minus one for each region.
  function automatic logic [CW-1:0] hold_cycles(input region_e rg);
    case (rg)
      RG_DRAM:                  return CW'(DRAM_CYC - 1);
      RG_IO_FAST, RG_SRAM_FAST: return CW'(FAST_CYC - 1);
      RG_IO_SLOW, RG_SRAM_SLOW: return CW'(SLOW_CYC - 1);
      default:                  return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cur     <= '0;
      cnt     <= '0;
      rdata_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          cur <= start_x;
          cnt <= hold_cycles(start_x.rg);
          st  <= (start_x.rg == RG_DRAM) ? ST_ROW : ST_XFER;
        end
        ST_ROW:  st <= ST_XFER;
        ST_XFER: if (cnt == '0) begin
          rdata_q <= cap_data;
          st      <= ST_DONE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (st == ST_IDLE);
  assign done      = (st == ST_DONE);
  assign done_vid  = done & cur.owner_vid;
  assign xfer_last = (st == ST_XFER) && (cnt == '0);
  assign cfg_we    = xfer_last && (cur.rg == RG_CFG) && cur.we;
  assign rdata     = rdata_q;
  assign phys      = sram_phys(cur.addr, cfg_q);

  always_comb begin
    case (cur.rg)
      RG_DRAM, RG_IO_FAST, RG_IO_SLOW: cap_data = {ext_hi_i, ext_d_i};
      RG_SRAM_FAST, RG_SRAM_SLOW:      cap_data = {{(DATA_W-BYTE_W){1'b0}}, ext_d_i[BYTE_W-1:0]};
      RG_CFG:                          cap_data = cfg_q;
      default:                         cap_data = '0;
    endcase
  end

  always_comb begin
    ext_a         = '0;
    ext_hi_o      = '0;
    ext_hi_oe     = 1'b0;
    ext_d_o       = '0;
    ext_d_oe      = 1'b0;
    ext_ras_n     = 1'b1;
    ext_cas_n     = 1'b1;
    ext_sram_cs_n = 1'b1;
    ext_io_cs_n   = 1'b1;
    ext_we_n      = 1'b1;
    if (st == ST_ROW) begin
      ext_ras_n = 1'b0;
      ext_a     = cur.addr[19:10];
    end else if (st == ST_XFER) begin
      case (cur.rg)
        RG_DRAM, RG_IO_FAST, RG_IO_SLOW: begin
          if (cur.rg == RG_DRAM) begin
            ext_ras_n = 1'b0;
            ext_cas_n = 1'b0;
          end else begin
            ext_io_cs_n = 1'b0;
          end
          ext_a     = cur.addr[9:0];
          ext_we_n  = ~cur.we;
          ext_hi_o  = cur.wdata[19:10];
          ext_d_o   = cur.wdata[9:0];
          ext_hi_oe = cur.we;
          ext_d_oe  = cur.we;
        end
        RG_SRAM_FAST, RG_SRAM_SLOW: begin
          ext_sram_cs_n = 1'b0;
          ext_a         = phys[9:0];
          ext_hi_o      = phys[19:10];
          ext_hi_oe     = 1'b1;
          ext_we_n      = ~cur.we;
          ext_d_o       = {{(PIN_W-BYTE_W){1'b0}}, cur.wdata[BYTE_W-1:0]};
          ext_d_oe      = cur.we;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/membus_coproc.sv
module membus_coproc
  import membus_pkg::*;
#(
  parameter int DRAM_CYC = 2,
  parameter int FAST_CYC = 2,
  parameter int SLOW_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vid_req,
  input  logic [20:0]       vid_addr,
  output logic              vid_rdy,
  output logic [19:0]       vid_rdata,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [20:0]       cpu_addr,
  input  logic [19:0]       cpu_wdata,
  output logic              cpu_rdy,
  output logic [19:0]       cpu_rdata,
  output logic [9:0]        ext_a,
  output logic [9:0]        ext_hi_o,
  output logic              ext_hi_oe,
  input  logic [9:0]        ext_hi_i,
  output logic [9:0]        ext_d_o,
  output logic              ext_d_oe,
  input  logic [9:0]        ext_d_i,
  output logic              ext_ras_n,
  output logic              ext_cas_n,
  output logic              ext_sram_cs_n,
  output logic              ext_io_cs_n,
  output logic              ext_we_n
);
  logic              seq_idle;
  logic              gnt_vid;
  logic              gnt_cpu;
  logic              seq_done;
  logic              seq_done_vid;
  logic              xfer_last;
  logic              cfg_we;
  logic [DATA_W-1:0] cfg_q;
  logic [DATA_W-1:0] rdata;
  xfer_t             start_x;

  membus_arb u_arb (
    .en      (seq_idle),
    .vid_req (vid_req),
    .cpu_req (cpu_req),
    .gnt_vid (gnt_vid),
    .gnt_cpu (gnt_cpu)
  );

  always_comb begin
    if (gnt_vid) begin
      start_x.owner_vid = 1'b1;
      start_x.we        = 1'b0;
      start_x.addr      = vid_addr;
      start_x.wdata     = '0;
    end else begin
      start_x.owner_vid = 1'b0;
      start_x.we        = cpu_we;
      start_x.addr      = cpu_addr;
      start_x.wdata     = cpu_wdata;
    end
    start_x.rg = decode_region(start_x.addr);
  end

  membus_cfg #(.W(DATA_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_data (cpu_wdata),
    .cfg_q   (cfg_q)
  );

  membus_seq #(
    .DRAM_CYC (DRAM_CYC),
    .FAST_CYC (FAST_CYC),
    .SLOW_CYC (SLOW_CYC)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (gnt_vid | gnt_cpu),
    .start_x       (start_x),
    .cfg_q         (cfg_q),
    .idle          (seq_idle),
    .done          (seq_done),
    .done_vid      (seq_done_vid),
    .xfer_last     (xfer_last),
    .cfg_we        (cfg_we),
    .rdata         (rdata),
    .ext_a         (ext_a),
    .ext_hi_o      (ext_hi_o),
    .ext_hi_oe     (ext_hi_oe),
    .ext_hi_i      (ext_hi_i),
    .ext_d_o       (ext_d_o),
    .ext_d_oe      (ext_d_oe),
    .ext_d_i       (ext_d_i),
    .ext_ras_n     (ext_ras_n),
    .ext_cas_n     (ext_cas_n),
    .ext_sram_cs_n (ext_sram_cs_n),
    .ext_io_cs_n   (ext_io_cs_n),
    .ext_we_n      (ext_we_n)
  );

  // The processor's write data must hold until ready, so the setup register
  // loads straight from the request port on the final data cycle.
  assign vid_rdy   = seq_done_vid;
  assign cpu_rdy   = seq_done & ~seq_done_vid;
  assign vid_rdata = rdata;
  assign cpu_rdata = rdata;
endmodule

// File: rtl/membus_coproc_chk.sv
module membus_coproc_chk (
  input logic clk,
  input logic rst_n,
  input logic vid_req,
  input logic gnt_vid,
  input logic gnt_cpu,
  input logic vid_rdy,
  input logic cpu_rdy,
  input logic ext_ras_n,
  input logic ext_cas_n,
  input logic ext_sram_cs_n,
  input logic ext_io_cs_n,
  input logic ext_we_n
);
  // R1
  a_r1_video_first: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_cpu |-> !vid_req);
  // R1
  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_vid && gnt_cpu));
  // R9
  a_r9_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vid_rdy, cpu_rdy}));
  // R9
  a_r9_cpu_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdy |=> !cpu_rdy);
  // R9
  a_r9_vid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vid_rdy |=> !vid_rdy);
  // R2
  a_r2_row_before_col: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_cas_n) |-> !$past(ext_ras_n));
  // R2
  a_r2_col_inside_row: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_cas_n |-> !ext_ras_n);
  // R11
  a_r11_one_device: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!ext_ras_n, !ext_sram_cs_n, !ext_io_cs_n}));
  // R11
  a_r11_write_needs_device: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_we_n |-> (!ext_cas_n || !ext_sram_cs_n || !ext_io_cs_n));
endmodule

bind membus_coproc membus_coproc_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .vid_req       (vid_req),
  .gnt_vid       (gnt_vid),
  .gnt_cpu       (gnt_cpu),
  .vid_rdy       (vid_rdy),
  .cpu_rdy       (cpu_rdy),
  .ext_ras_n     (ext_ras_n),
  .ext_cas_n     (ext_cas_n),
  .ext_sram_cs_n (ext_sram_cs_n),
  .ext_io_cs_n   (ext_io_cs_n),
  .ext_we_n      (ext_we_n)
);

// File: tb/tb_membus_coproc.sv
module tb_membus_coproc;
  localparam int CLK_P    = 10;
  localparam int DRAM_CYC = 2;
  localparam int FAST_CYC = 2;
  localparam int SLOW_CYC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vid_req = 0, cpu_req = 0, cpu_we = 0;
  logic [20:0] vid_addr = '0, cpu_addr = '0;
  logic [19:0] cpu_wdata = '0;
  logic vid_rdy, cpu_rdy;
  logic [19:0] vid_rdata, cpu_rdata;
  logic [9:0] ext_a, ext_hi_o, ext_d_o;
  logic [9:0] ext_hi_i = '0, ext_d_i = '0;
  logic ext_hi_oe, ext_d_oe, ext_ras_n, ext_cas_n, ext_sram_cs_n, ext_io_cs_n, ext_we_n;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  membus_coproc #(.DRAM_CYC(DRAM_CYC), .FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC)) dut (
    .clk(clk), .rst_n(rst_n),
    .vid_req(vid_req), .vid_addr(vid_addr), .vid_rdy(vid_rdy), .vid_rdata(vid_rdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata),
    .ext_a(ext_a), .ext_hi_o(ext_hi_o), .ext_hi_oe(ext_hi_oe), .ext_hi_i(ext_hi_i),
    .ext_d_o(ext_d_o), .ext_d_oe(ext_d_oe), .ext_d_i(ext_d_i),
    .ext_ras_n(ext_ras_n), .ext_cas_n(ext_cas_n), .ext_sram_cs_n(ext_sram_cs_n),
    .ext_io_cs_n(ext_io_cs_n), .ext_we_n(ext_we_n)
  );

  // ---------------- behavioural devices on the pins ----------------
  logic [19:0] pm_dram [bit [19:0]];
  logic [7:0]  pm_sram [bit [19:0]];
  logic [19:0] pm_io   [bit [9:0]];
  logic [9:0]  seen_row, seen_col, seen_io;
  logic [19:0] seen_sram;
  bit          any_sel;

  function automatic logic [19:0] fill(input logic [19:0] k);
    return k ^ 20'hA5C3F;
  endfunction

  always @(negedge clk) begin
    if (!ext_ras_n && ext_cas_n) seen_row = ext_a;
    if (!ext_cas_n) begin
      any_sel  = 1;
      seen_col = ext_a;
      if (!ext_we_n) pm_dram[{seen_row, ext_a}] = {ext_hi_o, ext_d_o};
      else {ext_hi_i, ext_d_i} = pm_dram.exists({seen_row, ext_a}) ?
                                 pm_dram[{seen_row, ext_a}] : fill({seen_row, ext_a});
    end
    if (!ext_sram_cs_n) begin
      any_sel   = 1;
      seen_sram = {ext_hi_o, ext_a};
      if (!ext_we_n) pm_sram[{ext_hi_o, ext_a}] = ext_d_o[7:0];
      else ext_d_i = {2'b11, pm_sram.exists({ext_hi_o, ext_a}) ?
                             pm_sram[{ext_hi_o, ext_a}] : fill({ext_hi_o, ext_a})[7:0]};
    end
    if (!ext_io_cs_n) begin
      any_sel = 1;
      seen_io = ext_a;
      if (!ext_we_n) pm_io[ext_a] = {ext_hi_o, ext_d_o};
      else {ext_hi_i, ext_d_i} = pm_io.exists(ext_a) ? pm_io[ext_a] : fill({10'h0, ext_a});
    end
    if (!ext_ras_n && !ext_sram_cs_n) any_sel = 1;
  end

  // ---------------- bench reference ----------------
  logic [19:0] ref_dram [bit [19:0]];
  logic [7:0]  ref_sram [bit [19:0]];
  logic [19:0] ref_io   [bit [9:0]];
  logic [19:0] ref_cfg = '0;

  // 0 none, 1 dram, 2 sram fast, 3 sram slow, 4 io fast, 5 io slow, 6 setup reg
  function automatic int region_of(input logic [20:0] a);
    if (a <= 21'h0FFFFF) return 1;
    if (a >= 21'h180000 && a <= 21'h1BFFFF) return 2;
    if (a >= 21'h1C0000) return 3;
    if (a >= 21'h160000 && a <= 21'h1603FF) return 4;
    if (a >= 21'h120000 && a <= 21'h1203FF) return 5;
    if (a == 21'h140000) return 6;
    return 0;
  endfunction

  function automatic int latency_of(input int rg);
    case (rg)
      1: return 2 + DRAM_CYC;
      2, 4: return 1 + FAST_CYC;
      3, 5: return 1 + SLOW_CYC;
      default: return 2;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic access(input bit vid, input bit we, input logic [20:0] addr,
                        input logic [19:0] wd);
    int lat, rg, stray;
    logic [19:0] got, expv, key;
    rg = region_of(addr);
    @(negedge clk);
    any_sel = 0;
    if (vid) begin vid_req = 1; vid_addr = addr; end
    else begin cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; end
    lat = 0; stray = 0;
    do begin
      @(negedge clk);
      lat++;
      if (vid ? cpu_rdy : vid_rdy) stray++;
    end while (!(vid ? vid_rdy : cpu_rdy) && lat < 40);
    got = vid ? vid_rdata : cpu_rdata;
    vid_req = 0; cpu_req = 0;
    check(lat == latency_of(rg), "R8 latency", lat, latency_of(rg));
    check(stray == 0, "R9 ready to owner only", stray, 0);
    expv = '0;
    case (rg)
      1: begin
        key = addr[19:0];
        check({seen_row, seen_col} == key, "R2 row/column pins", {seen_row, seen_col}, key);
        if (we) ref_dram[key] = wd;
        else expv = ref_dram.exists(key) ? ref_dram[key] : fill(key);
      end
      2, 3: begin
        key = {ref_cfg[19:18], addr[17:0]};
        check(seen_sram == key, "R6 paged address", seen_sram, key);
        if (we) ref_sram[key] = wd[7:0];
        else expv = {12'h0, ref_sram.exists(key) ? ref_sram[key] : fill(key)[7:0]};
      end
      4, 5: begin
        check(seen_io == addr[9:0], "R7 peripheral address", seen_io, addr[9:0]);
        if (we) ref_io[addr[9:0]] = wd;
        else expv = ref_io.exists(addr[9:0]) ? ref_io[addr[9:0]] : fill({10'h0, addr[9:0]});
      end
      6: begin
        check(!any_sel, "R5 no pin activity", any_sel, 0);
        if (we) ref_cfg = wd; else expv = ref_cfg;
      end
      default: check(!any_sel, "R10 no select", any_sel, 0);
    endcase
    if (!we || vid) check(got == expv, $sformatf("R3/R4 read region %0d", rg), got, expv);
  endtask

  function automatic logic [20:0] rand_addr(input int sel, input logic [31:0] r);
    case (sel)
      0, 1, 2: return {1'b0, r[19:0] & 20'hC0C03};
      3:       return {1'b1, 2'b10, r[17:0] & 18'h30003};
      4:       return {1'b1, 2'b11, r[17:0] & 18'h30003};
      5:       return {1'b1, r[20] ? 3'b001 : 3'b011, 7'h0, r[9:0] & 10'h00F};
      6:       return 21'h140000;
      default: return r[21] ? {1'b1, 3'b000, r[16:0]} : {1'b1, 3'b001, 7'h01, r[9:0]};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int vlat, clat, cyc;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // reset state
    check(!cpu_rdy && !vid_rdy, "R9 reset ready low", {cpu_rdy, vid_rdy}, 0);
    check(ext_ras_n && ext_cas_n && ext_sram_cs_n && ext_io_cs_n && ext_we_n,
          "R11 reset strobes idle", 0, 1);
    check(cpu_rdata == 0, "R10 reset data zero", cpu_rdata, 0);

    // R5: setup register reset value and write/readback
    access(0, 0, 21'h140000, '0);
    access(0, 1, 21'h140000, 20'hC1234);
    access(0, 0, 21'h140000, '0);
    // R6: paging
    access(0, 1, 21'h180005, 20'h000A7);
    access(0, 0, 21'h1C0005, '0);
    access(0, 1, 21'h140000, 20'h40000);
    access(0, 0, 21'h1C0005, '0);
    access(1, 0, 21'h1BFFFF, '0);
    // R2/R3: dram write and read back
    access(0, 1, 21'h0ABCDE, 20'h5F0E1);
    access(1, 0, 21'h0ABCDE, '0);
    access(0, 0, 21'h0FFFFF, '0);
    // R7: both windows reach the same location
    access(0, 1, 21'h160010, 20'h3C3C3);
    access(0, 0, 21'h120010, '0);
    access(1, 0, 21'h1603FF, '0);
    // R10: unmapped holes
    access(0, 0, 21'h100000, '0);
    access(0, 0, 21'h120400, '0);
    access(0, 0, 21'h140001, '0);
    access(0, 1, 21'h160400, 20'hFFFFF);

    // R1: simultaneous requests
    @(negedge clk);
    vid_req = 1; vid_addr = 21'h0ABCDE;
    cpu_req = 1; cpu_we = 0; cpu_addr = 21'h140000;
    vlat = 0; clat = 0; cyc = 0;
    while ((vid_req || cpu_req) && cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (vid_rdy) begin
        vlat = cyc; vid_req = 0;
        check(vid_rdata == 20'h5F0E1, "R1 video data", vid_rdata, 20'h5F0E1);
      end
      if (cpu_rdy) begin
        clat = cyc; cpu_req = 0;
        check(cpu_rdata == ref_cfg, "R1 processor data", cpu_rdata, ref_cfg);
      end
    end
    check(vlat == 2 + DRAM_CYC, "R1 video served first", vlat, 2 + DRAM_CYC);
    check(clat > vlat, "R1 processor after video", clat, vlat + 1);

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      int sel;
      bit v, w;
      r   = $urandom;
      sel = int'($urandom % 8);
      v   = ($urandom % 3) == 0;
      w   = !v && ($urandom % 2);
      access(v, w, rand_addr(sel, r), $urandom);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule